// File: doc/BRIEF.md
# Half-Duplex Open-Drain Line Arbiter

This block sits between two open-drain, active-low data wires: one toward a host controller and one toward a card. It watches the level of each wire and, when one side pulls low, it copies that low onto the other side through a pull-down enable. The first side seen low becomes the input of the transfer and the other side becomes the output. The block remembers this direction and will not copy a low back from the output side. This keeps the two sides from holding each other low for ever. The direction is only released once both wires read high again.

Two control inputs gate the block. While the supply-ready input is low, the card wire is held low, the host wire is left undriven and nothing is relayed. While the chip-select input is high, neither wire is driven and nothing is relayed. Each wire level passes through a two-flop synchronizer before the decision logic uses it. A two-bit status output reports the current direction.

Top module: `hdlx_line_arbiter`

## Requirements
- R1: After reset the status reads idle (2'b00), `host_pull_o` is 0 and `card_pull_o` is 1.
- R2: From the idle condition with the block enabled, a low on the host wire sets status 2'b01 (host-to-card). `card_pull_o` rises on the third rising clock edge after the wire falls (two synchronizer stages plus one output register).
- R3: From the idle condition with the block enabled, a low on the card wire sets status 2'b10 (card-to-host), and `host_pull_o` rises on the third edge.
- R4: While the status is host-to-card, `host_pull_o` stays 0. While the status is card-to-host, `card_pull_o` stays 0. The two pull enables are never 1 together.
- R5: When the input-side wire returns high, the output-side pull drops on the third edge. Once both wires read high, the status returns to idle, and a new low from either side is then accepted.
- R6: If the output-side wire is held low from outside after the input side has released, that low is not relayed, and the status keeps its direction until both wires are high.
- R7: While `ready_i` is 0, `card_pull_o` is 1, `host_pull_o` is 0 and the status is idle, whatever the wires do.
- R8: While `cs_n_i` is 1 (and `ready_i` is 1), both pull enables are 0 and the status is idle, whatever the wires do.
- R9: After the block is enabled again, no direction is chosen until both synchronized wires have read high. A low still present from the disabled period is not relayed.
- R10: If both wires are seen low in the same sample cycle from idle, the host side becomes the input (status 2'b01).
- R11: A direction changes only through idle. Host-to-card is never followed directly by card-to-host, nor the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ready_i | input | 1 | Supply stable; 0 holds the card wire low and disables relaying |
| cs_n_i | input | 1 | Chip select, active low; 1 disables both drivers |
| host_line_i | input | 1 | Sampled level of the host-side wire |
| card_line_i | input | 1 | Sampled level of the card-side wire |
| host_pull_o | output | 1 | Pull-down enable for the host-side wire |
| card_pull_o | output | 1 | Pull-down enable for the card-side wire |
| dir_o | output | 2 | Direction: 00 idle, 01 host-to-card, 10 card-to-host |

## Verification
The hardest situation to reach is the latch hazard. The block's own pull-down on the output wire comes back through the synchronizer while the input wire is still low, or the output wire is held low from outside after the input wire has let go. The bench models both wires as open-drain nets: each wire is the wired-AND of the block's pull and an external pull. The block therefore sees its own drive come back, just as it would on a real board. The bench then holds the external pull on the output side across the input release. It also brings the block up from not-ready while the card wire is still held low by the block itself.

// File: rtl/hdlx_pkg.sv
// Shared types for the half-duplex line arbiter.
// Assumes: status encoding is visible at the top-level port.
package hdlx_pkg;

    // Internal arbiter state; OFF means disabled or waiting for both lines high.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_H2C  = 2'd2,
        ST_C2H  = 2'd3
    } arb_state_e;

    // Reported direction code.
    localparam logic [1:0] DIR_IDLE = 2'b00;
    localparam logic [1:0] DIR_H2C  = 2'b01;
    localparam logic [1:0] DIR_C2H  = 2'b10;

endpackage

// File: rtl/hdlx_sync.sv
// Multi-stage synchronizer for asynchronous line levels.
// Assumes: idle level of every bit is given by RST_VAL; reset is synchronous, active low.
module hdlx_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the level one stage toward the consumer.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= {WIDTH{RST_VAL}};
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/hdlx_dir_fsm.sv
// Direction arbiter: locks the transfer direction to the first side seen low.
// Assumes: host_s/card_s are synchronized levels; enable = ready and chip-select active.
module hdlx_dir_fsm
    import hdlx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       host_s_i,
    input  logic       card_s_i,
    output arb_state_e state_d_o,
    output arb_state_e state_q_o,
    output logic [1:0] dir_o
);
    arb_state_e state_q, state_d;
    logic       both_high;

    assign both_high = host_s_i && card_s_i;

    // Next-state decision; host wins a same-cycle tie.
    always_comb begin
        state_d = state_q;
        if (!enable_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  if (both_high) state_d = ST_IDLE;
                ST_IDLE: begin
                    if (!host_s_i)      state_d = ST_H2C;
                    else if (!card_s_i) state_d = ST_C2H;
                end
                ST_H2C:  if (both_high) state_d = ST_IDLE;
                ST_C2H:  if (both_high) state_d = ST_IDLE;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Map internal state to the reported direction code.
    always_comb begin
        unique case (state_q)
            ST_H2C:  dir_o = DIR_H2C;
            ST_C2H:  dir_o = DIR_C2H;
            default: dir_o = DIR_IDLE;
        endcase
    end

    assign state_d_o = state_d;
    assign state_q_o = state_q;

    // R11: a locked direction never flips straight to the opposite one.
    a_r11_no_direct_flip_h: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_H2C |=> state_q != ST_C2H);
    a_r11_no_direct_flip_c: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_C2H |=> state_q != ST_H2C);
    // R9: a disabled arbiter only rearms through idle.
    a_r9_rearm_via_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_OFF |=> (state_q == ST_OFF || state_q == ST_IDLE));

endmodule

// File: rtl/hdlx_pull_drv.sv
// Registered pull-down enables for both lines.
// Assumes: state_d is the arbiter's next state, levels are synchronized.
module hdlx_pull_drv
    import hdlx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready_i,
    input  logic       cs_n_i,
    input  arb_state_e state_d_i,
    input  logic       host_s_i,
    input  logic       card_s_i,
    output logic       host_pull_o,
    output logic       card_pull_o
);
    logic host_pull_d, card_pull_d;

    // Decide each pull: not-ready forces card low, else relay only the input side's low.
    always_comb begin
        if (!ready_i) begin
            host_pull_d = 1'b0;
            card_pull_d = 1'b1;
        end else if (cs_n_i) begin
            host_pull_d = 1'b0;
            card_pull_d = 1'b0;
        end else begin
            card_pull_d = (state_d_i == ST_H2C) && !host_s_i;
            host_pull_d = (state_d_i == ST_C2H) && !card_s_i;
        end
    end

    // Output registers; reset matches the not-ready condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_pull_o <= 1'b0;
            card_pull_o <= 1'b1;
        end else begin
            host_pull_o <= host_pull_d;
            card_pull_o <= card_pull_d;
        end
    end

    // R7: not-ready holds the card line low and leaves the host line undriven.
    a_r7_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> card_pull_o && !host_pull_o);
    // R8: chip-select high releases both lines.
    a_r8_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && cs_n_i) |=> !card_pull_o && !host_pull_o);

endmodule

// File: rtl/hdlx_line_arbiter.sv
// Top level: synchronizes both line levels, arbitrates direction, drives pulls.
// Assumes: lines are open-drain with external pull-ups; levels arrive asynchronously.
module hdlx_line_arbiter
    import hdlx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready_i,
    input  logic       cs_n_i,
    input  logic       host_line_i,
    input  logic       card_line_i,
    output logic       host_pull_o,
    output logic       card_pull_o,
    output logic [1:0] dir_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] lines_s;
    logic              host_s, card_s, enable;
    arb_state_e        state_d, state_q;

    assign enable = ready_i && !cs_n_i;

    hdlx_sync #(
        .WIDTH  (NLINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({card_line_i, host_line_i}),
        .sync_o (lines_s)
    );

    assign host_s = lines_s[0];
    assign card_s = lines_s[1];

    hdlx_dir_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable),
        .host_s_i (host_s),
        .card_s_i (card_s),
        .state_d_o(state_d),
        .state_q_o(state_q),
        .dir_o    (dir_o)
    );

    hdlx_pull_drv u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready_i),
        .cs_n_i     (cs_n_i),
        .state_d_i  (state_d),
        .host_s_i   (host_s),
        .card_s_i   (card_s),
        .host_pull_o(host_pull_o),
        .card_pull_o(card_pull_o)
    );

    // R4: no reverse relay while host-to-card is locked.
    a_r4_no_reverse_h2c: assert property (@(posedge clk) disable iff (!rst_n)
        dir_o == DIR_H2C |-> !host_pull_o);
    // R4: no reverse relay while card-to-host is locked.
    a_r4_no_reverse_c2h: assert property (@(posedge clk) disable iff (!rst_n)
        dir_o == DIR_C2H |-> !card_pull_o);
    // R4: the two pulls are never active together.
    a_r4_pulls_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_pull_o, card_pull_o}));
    // R5: leaving a direction lands in idle.
    a_r5_exit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_o == DIR_H2C && ready_i && !cs_n_i) |=> (dir_o == DIR_H2C || dir_o == DIR_IDLE));

endmodule

// File: tb/tb_hdlx_line_arbiter.sv
module tb_hdlx_line_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ready = 1'b0;
    logic       cs_n = 1'b0;
    logic       host_ext = 1'b0;
    logic       card_ext = 1'b0;
    logic       host_line, card_line;
    logic       host_pull, card_pull;
    logic [1:0] dir;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    // Open-drain wire model: low if either side pulls.
    assign host_line = ~(host_pull | host_ext);
    assign card_line = ~(card_pull | card_ext);

    hdlx_line_arbiter dut (
        .clk(clk), .rst_n(rst_n), .ready_i(ready), .cs_n_i(cs_n),
        .host_line_i(host_line), .card_line_i(card_line),
        .host_pull_o(host_pull), .card_pull_o(card_pull), .dir_o(dir)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_state(input string req, input int hp, input int cp, input int d);
        chk(host_pull == hp, {req, " host_pull"}, host_pull, hp);
        chk(card_pull == cp, {req, " card_pull"}, card_pull, cp);
        chk(dir == d, {req, " dir"}, dir, d);
    endtask

    task automatic t_reset;
        // R1: reset values.
        rst_n = 1'b0; ready = 1'b1; cs_n = 1'b0;
        cyc(3);
        chk_state("R1", 0, 1, 0);
        rst_n = 1'b1;
        cyc(8);
    endtask

    task automatic t_host_to_card;
        host_ext = 1'b1;
        cyc(2);
        chk(card_pull == 0, "R2 before third edge", card_pull, 0);
        cyc(1);
        chk_state("R2", 0, 1, 1);
        cyc(10);
        chk_state("R4 own echo ignored", 0, 1, 1);
        host_ext = 1'b0;
        cyc(2);
        chk(card_pull == 1, "R5 pull held two edges", card_pull, 1);
        cyc(1);
        chk(card_pull == 0, "R5 pull released", card_pull, 0);
        cyc(6);
        chk_state("R5 back to idle", 0, 0, 0);
    endtask

    task automatic t_card_to_host;
        card_ext = 1'b1;
        cyc(3);
        chk_state("R3", 1, 0, 2);
        cyc(10);
        chk_state("R4 card lock", 1, 0, 2);
        card_ext = 1'b0;
        cyc(9);
        chk_state("R5 idle after card", 0, 0, 0);
    endtask

    task automatic t_held_output;
        host_ext = 1'b1;
        cyc(4);
        card_ext = 1'b1;
        cyc(2);
        host_ext = 1'b0;
        cyc(12);
        chk_state("R6 held low not relayed", 0, 0, 1);
        card_ext = 1'b0;
        cyc(8);
        chk_state("R6 idle after release", 0, 0, 0);
        // R5: new direction accepted from the other side.
        card_ext = 1'b1;
        cyc(3);
        chk_state("R5 new direction", 1, 0, 2);
        card_ext = 1'b0;
        cyc(9);
    endtask

    task automatic t_tie;
        host_ext = 1'b1; card_ext = 1'b1;
        cyc(3);
        chk_state("R10 host wins tie", 0, 1, 1);
        host_ext = 1'b0; card_ext = 1'b0;
        cyc(9);
        chk(dir == 0, "R10 idle after tie", dir, 0);
    endtask

    task automatic t_not_ready;
        host_ext = 1'b1;
        cyc(4);
        ready = 1'b0;
        cyc(1);
        chk_state("R7 mid-transfer drop", 0, 1, 0);
        cyc(8);
        chk_state("R7 no relay", 0, 1, 0);
        host_ext = 1'b0;
        ready = 1'b1;
        cyc(12);
        chk_state("R9 own low not relayed", 0, 0, 0);
        card_ext = 1'b1;
        cyc(3);
        chk_state("R9 relay after rearm", 1, 0, 2);
        card_ext = 1'b0;
        cyc(9);
    endtask

    task automatic t_cs_high;
        cs_n = 1'b1;
        card_ext = 1'b1;
        cyc(8);
        chk_state("R8 cs high", 0, 0, 0);
        cs_n = 1'b0;
        cyc(8);
        chk_state("R9 stale low ignored", 0, 0, 0);
        card_ext = 1'b0;
        cyc(6);
        host_ext = 1'b1;
        cyc(3);
        chk_state("R9 rearmed after cs", 0, 1, 1);
        host_ext = 1'b0;
        cyc(9);
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_host_to_card();
        t_card_to_host();
        t_held_output();
        t_tie();
        t_not_ready();
        t_cs_high();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule